// File: doc/BRIEF.md
# Cycle-Steal Arbiter with Entry Sampling

This block is the direct-memory-access front end of a small word-oriented computer. Four request levels compete for memory. Level 0 is the most urgent and level 3 the least. When memory is idle the block grants one level. It then runs that level's memory cycle through eight clock phases, numbered 0 to 7. Phases 0 to 3 form the read half and phases 4 to 7 form the write-back half. After phase 7 the block spends one idle clock before it weighs the requests again.

At phase 3 the block decides whether the storage buffer register takes its value from the I/O data bus, so that the value is written back to the granted address. Each level follows its own rule:

- Level 0 needs its file-entry gate.
- Level 1 needs an external entry strobe, unless a strap parameter forces it to sample on every cycle.
- Level 2 never samples, because its device only reads memory.
- Level 3 always samples.

A built-in loader sits on level 1. It accepts one (address, data) word at a time and requests a cycle for each word. It keeps its address and data lines steady for a fixed number of clocks after it drops its request. It raises a done flag once the final word has been written. The block also watches the shared address-bus drive enables and flags any source that drives the bus while another level owns it.

Top module: `cs_steal_front`

## Requirements
- R1: After reset the block shows the following state: grant_o is 0, busy_o is 0, phase_o is 0, sbr_o is 0, mem_we_o is 0, bus_err_o is 0, ld_ready_o is 1, ld_done_o is 0 and lreq_o is 0.
- R2: On an idle clock with any request pending, the block grants the pending level with the lowest index. Bit i of grant_o stands for level i, and grant_o has at most one bit set. The loader adds a request on level 1.
- R3: A granted cycle shows phase_o values 0,1,...,7, one per clock, with busy_o high and grant_o constant. One idle clock follows, with busy_o low, phase_o 0 and grant_o 0. Requests are evaluated on that idle clock.
- R4: In a level-0 cycle, entry_sample_o is high during phase 3 exactly when file_gate_i is high.
- R5: In a level-1 cycle, entry_sample_o is high during phase 3 when any of three things holds: ent_strobe_i is high, the cycle serves the loader, or the L1_ALWAYS strap is set.
- R6: A level-2 cycle never raises entry_sample_o.
- R7: A level-3 cycle always raises entry_sample_o during phase 3.
- R8: entry_sample_o is never high outside phase 3 of a busy cycle.
- R9: The storage buffer register loads on the clock edge that ends a sampled phase 3. In loader cycles it takes the loader's data, and otherwise it takes iobus_i. mem_we_o is high during phase 6 of sampled cycles only. While busy, mem_addr_o carries the loader's address in loader cycles and ext_addr_i otherwise. When idle it is 0.
- R10: When ld_ready_o and ld_valid_i are both high, the loader captures the word and raises lreq_o. It drops lreq_o on the clock after the X7 of its level-1 cycle. It then holds laddr_o and ldata_o for HOLD_CYC clocks with ld_ready_o low before it becomes ready again.
- R11: ld_done_o rises together with the lreq_o drop for a word that was flagged last with ld_last_i. It clears when the next word is accepted.
- R12: bus_err_o is high on the clock after any busy clock in which a level other than the granted one had its drive enable (addr_drv_i bit, or the loader's own drive) set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| req_i | input | 4 | External request per level, bit i is level i |
| addr_drv_i | input | 4 | Per-level address-bus drive enables from peripherals |
| file_gate_i | input | 1 | Level-0 file-entry gate |
| ent_strobe_i | input | 1 | Level-1 external entry strobe |
| iobus_i | input | DW | I/O data bus |
| ext_addr_i | input | AW | Address presented by the peripheral that owns the cycle |
| ld_valid_i | input | 1 | Loader word valid |
| ld_addr_i | input | AW | Loader word address |
| ld_data_i | input | DW | Loader word data |
| ld_last_i | input | 1 | Loader word is the final one |
| ld_ready_o | output | 1 | Loader can accept a word |
| ld_done_o | output | 1 | Final loader word written |
| lreq_o | output | 1 | Loader's level-1 request line |
| laddr_o | output | AW | Loader's held address lines |
| ldata_o | output | DW | Loader's held data lines |
| grant_o | output | 4 | One-hot granted level |
| busy_o | output | 1 | Memory cycle in progress |
| phase_o | output | 3 | Current cycle phase |
| entry_sample_o | output | 1 | Latch I/O bus into storage buffer this clock |
| sbr_o | output | DW | Storage buffer register |
| mem_addr_o | output | AW | Memory address bus |
| mem_we_o | output | 1 | Write-back strobe |
| bus_err_o | output | 1 | Address-bus contention flag |

## Verification
The assertions check several properties on every clock:

- grant_o has at most one bit set.
- Each new grant goes to the most urgent level that was requesting.
- Phases advance one per clock.
- Sampling happens only at phase 3, never on level 2 and always on level 3.
- Write strobes appear only in phase 6.
- The loader's lines do not move when its request falls.
- Contention is flagged.

Only the bench's scenarios can show the rest:

- the per-level gate and strobe dependence on levels 0 and 1;
- the order of service when all four levels request at once;
- which value ends up in the buffer register;
- the hold length and done timing of the loader across a stream of words that interleaves with level-0 traffic.

// File: rtl/cs_pkg.sv
package cs_pkg;

  localparam int NLVL      = 4;
  localparam int PH_W      = 3;
  localparam int PH_LAST   = 7;
  localparam int PH_SAMPLE = 3;
  localparam int PH_WRITE  = 6;

  // how a level decides to take the I/O bus into the buffer register
  typedef enum logic [1:0] {
    EM_GATED  = 2'd0,
    EM_STROBE = 2'd1,
    EM_NEVER  = 2'd2,
    EM_ALWAYS = 2'd3
  } entry_mode_e;

  typedef enum logic [1:0] {
    LD_IDLE = 2'd0,
    LD_REQ  = 2'd1,
    LD_HOLD = 2'd2
  } ld_state_e;

  function automatic entry_mode_e level_mode(input int lvl);
    case (lvl)
      0:       return EM_GATED;
      1:       return EM_STROBE;
      2:       return EM_NEVER;
      default: return EM_ALWAYS;
    endcase
  endfunction

endpackage

// File: rtl/cs_prio_pick.sv
module cs_prio_pick #(
  parameter int N = 4
) (
  input  logic [N-1:0] req_i,
  output logic [N-1:0] gnt_o,
  output logic         any_o
);

  always_comb begin
    gnt_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) gnt_o = N'(1) << i;
    end
  end

  assign any_o = |req_i;

endmodule

// File: rtl/cs_phase_seq.sv
module cs_phase_seq
  import cs_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  output logic            busy_o,
  output logic [PH_W-1:0] phase_o,
  output logic            last_o
);

  logic            busy_q, busy_d;
  logic [PH_W-1:0] phase_q, phase_d;

  assign last_o = busy_q && (phase_q == PH_W'(PH_LAST));

  always_comb begin
    busy_d  = busy_q;
    phase_d = phase_q;
    if (!busy_q) begin
      if (start_i) begin
        busy_d  = 1'b1;
        phase_d = '0;
      end
    end else if (last_o) begin
      busy_d  = 1'b0;
      phase_d = '0;
    end else begin
      phase_d = phase_q + PH_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      phase_q <= '0;
    end else begin
      busy_q  <= busy_d;
      phase_q <= phase_d;
    end
  end

  assign busy_o  = busy_q;
  assign phase_o = phase_q;

endmodule

// File: rtl/cs_entry_decode.sv
module cs_entry_decode
  import cs_pkg::*;
(
  input  logic [NLVL-1:0] grant_i,
  input  logic            at_x3_i,
  input  logic            gate_i,
  input  logic            strobe_i,
  output logic            sample_o
);

  logic [NLVL-1:0] hit;

  for (genvar l = 0; l < NLVL; l++) begin : g_lvl
    if (level_mode(l) == EM_GATED) begin : g_gated
      assign hit[l] = grant_i[l] & at_x3_i & gate_i;
    end else if (level_mode(l) == EM_STROBE) begin : g_strobe
      assign hit[l] = grant_i[l] & at_x3_i & strobe_i;
    end else if (level_mode(l) == EM_NEVER) begin : g_never
      assign hit[l] = grant_i[l] & at_x3_i & 1'b0;
    end else begin : g_always
      assign hit[l] = grant_i[l] & at_x3_i;
    end
  end

  assign sample_o = |hit;

endmodule

// File: rtl/cs_loader.sv
module cs_loader
  import cs_pkg::*;
#(
  parameter int AW       = 16,
  parameter int DW       = 16,
  parameter int HOLD_CYC = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          valid_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  input  logic          last_i,
  input  logic          cyc_done_i,
  output logic          ready_o,
  output logic          done_o,
  output logic          lreq_o,
  output logic [AW-1:0] laddr_o,
  output logic [DW-1:0] ldata_o
);

  localparam int CW = $clog2(HOLD_CYC + 1);

  ld_state_e     st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;
  logic          last_q;
  logic          done_q, done_d;
  logic          cap;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    done_d = done_q;
    cap    = 1'b0;
    case (st_q)
      LD_IDLE: begin
        if (valid_i) begin
          st_d   = LD_REQ;
          cap    = 1'b1;
          done_d = 1'b0;
        end
      end
      LD_REQ: begin
        if (cyc_done_i) begin
          st_d  = LD_HOLD;
          cnt_d = CW'(HOLD_CYC - 1);
          if (last_q) done_d = 1'b1;
        end
      end
      LD_HOLD: begin
        if (cnt_q == '0) st_d = LD_IDLE;
        else             cnt_d = cnt_q - CW'(1);
      end
      default: st_d = LD_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= LD_IDLE;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
      last_q <= 1'b0;
    end else if (cap) begin
      addr_q <= addr_i;
      data_q <= data_i;
      last_q <= last_i;
    end
  end

  assign ready_o = (st_q == LD_IDLE);
  assign lreq_o  = (st_q == LD_REQ);
  assign done_o  = done_q;
  assign laddr_o = addr_q;
  assign ldata_o = data_q;

endmodule

// File: rtl/cs_steal_front.sv
module cs_steal_front
  import cs_pkg::*;
#(
  parameter int AW        = 16,
  parameter int DW        = 16,
  parameter int HOLD_CYC  = 3,
  parameter bit L1_ALWAYS = 1'b0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NLVL-1:0] req_i,
  input  logic [NLVL-1:0] addr_drv_i,
  input  logic            file_gate_i,
  input  logic            ent_strobe_i,
  input  logic [DW-1:0]   iobus_i,
  input  logic [AW-1:0]   ext_addr_i,
  input  logic            ld_valid_i,
  input  logic [AW-1:0]   ld_addr_i,
  input  logic [DW-1:0]   ld_data_i,
  input  logic            ld_last_i,
  output logic            ld_ready_o,
  output logic            ld_done_o,
  output logic            lreq_o,
  output logic [AW-1:0]   laddr_o,
  output logic [DW-1:0]   ldata_o,
  output logic [NLVL-1:0] grant_o,
  output logic            busy_o,
  output logic [PH_W-1:0] phase_o,
  output logic            entry_sample_o,
  output logic [DW-1:0]   sbr_o,
  output logic [AW-1:0]   mem_addr_o,
  output logic            mem_we_o,
  output logic            bus_err_o
);

  // reset release synchroniser
  logic rs1_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q      <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rs1_q      <= 1'b1;
      rst_sync_n <= rs1_q;
    end
  end

  logic [NLVL-1:0] req_all, pick;
  logic            any_req, start, busy, last, at_x3, es;
  logic [PH_W-1:0] phase;
  logic [NLVL-1:0] grant_q, grant_d;
  logic            lreq, ld_cyc_done, loader_own, l1_strobe;
  logic [AW-1:0]   laddr;
  logic [DW-1:0]   ldata, data_mux;
  logic [DW-1:0]   sbr_q;
  logic            wr_q, wr_d, err_q, err_d;
  logic [NLVL-1:0] drv_all;

  assign req_all = req_i | (NLVL'(lreq) << 1);

  cs_prio_pick #(.N(NLVL)) u_pick (
    .req_i (req_all),
    .gnt_o (pick),
    .any_o (any_req)
  );

  assign start = !busy && any_req;

  cs_phase_seq u_seq (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .start_i (start),
    .busy_o  (busy),
    .phase_o (phase),
    .last_o  (last)
  );

  always_comb begin
    grant_d = grant_q;
    if (start)     grant_d = pick;
    else if (last) grant_d = '0;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) grant_q <= '0;
    else             grant_q <= grant_d;
  end

  assign loader_own  = lreq && grant_q[1];
  assign ld_cyc_done = grant_q[1] && last;

  cs_loader #(.AW(AW), .DW(DW), .HOLD_CYC(HOLD_CYC)) u_ld (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .valid_i    (ld_valid_i),
    .addr_i     (ld_addr_i),
    .data_i     (ld_data_i),
    .last_i     (ld_last_i),
    .cyc_done_i (ld_cyc_done),
    .ready_o    (ld_ready_o),
    .done_o     (ld_done_o),
    .lreq_o     (lreq),
    .laddr_o    (laddr),
    .ldata_o    (ldata)
  );

  assign at_x3     = busy && (phase == PH_W'(PH_SAMPLE));
  assign l1_strobe = ent_strobe_i | L1_ALWAYS | loader_own;

  cs_entry_decode u_dec (
    .grant_i  (grant_q),
    .at_x3_i  (at_x3),
    .gate_i   (file_gate_i),
    .strobe_i (l1_strobe),
    .sample_o (es)
  );

  assign data_mux = loader_own ? ldata : iobus_i;

  always_comb begin
    wr_d = wr_q;
    if (start)   wr_d = 1'b0;
    else if (es) wr_d = 1'b1;
  end

  assign drv_all = addr_drv_i | (NLVL'(loader_own) << 1);
  assign err_d   = busy && |(drv_all & ~grant_q);

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      wr_q  <= 1'b0;
      err_q <= 1'b0;
    end else begin
      wr_q  <= wr_d;
      err_q <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) sbr_q <= '0;
    else if (es)     sbr_q <= data_mux;
  end

  assign grant_o        = grant_q;
  assign busy_o         = busy;
  assign phase_o        = phase;
  assign entry_sample_o = es;
  assign sbr_o          = sbr_q;
  assign mem_we_o       = busy && (phase == PH_W'(PH_WRITE)) && wr_q;
  assign mem_addr_o     = !busy ? '0 : (loader_own ? laddr : ext_addr_i);
  assign bus_err_o      = err_q;
  assign lreq_o         = lreq;
  assign laddr_o        = laddr;
  assign ldata_o        = ldata;

endmodule

// File: rtl/cs_steal_chk.sv
module cs_steal_chk #(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [3:0]    req_all,
  input logic [3:0]    addr_drv,
  input logic [3:0]    grant,
  input logic          busy,
  input logic [2:0]    phase,
  input logic          es,
  input logic          mem_we,
  input logic          lreq,
  input logic          ld_ready,
  input logic [AW-1:0] laddr,
  input logic [DW-1:0] ldata,
  input logic          bus_err
);

  // R2
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  // R2
  grant_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ((($past(req_all) & (grant - 4'd1)) == 4'd0) &&
                     (($past(req_all) & grant) != 4'd0)));

  // R3
  phase_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && phase != 3'd7) |=> (busy && phase == $past(phase) + 3'd1 && $stable(grant)));

  // R3
  cycle_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && phase == 3'd7) |=> (!busy && grant == 4'd0));

  // R8
  sample_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    es |-> (busy && phase == 3'd3));

  // R6
  l2_no_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant[2] |-> !es);

  // R7
  l3_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && grant[3] && phase == 3'd3) |-> es);

  // R9
  we_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (busy && phase == 3'd6 && !grant[2]));

  // R10
  ld_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lreq) |-> ($stable(laddr) && $stable(ldata) && !ld_ready));

  // R12
  bus_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && ((addr_drv & ~grant) != 4'd0)) |=> bus_err);

  // R12
  bus_err_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> !bus_err);

endmodule

bind cs_steal_front cs_steal_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .req_all  (req_all),
  .addr_drv (addr_drv_i),
  .grant    (grant_o),
  .busy     (busy_o),
  .phase    (phase_o),
  .es       (entry_sample_o),
  .mem_we   (mem_we_o),
  .lreq     (lreq_o),
  .ld_ready (ld_ready_o),
  .laddr    (laddr_o),
  .ldata    (ldata_o),
  .bus_err  (bus_err_o)
);

// File: tb/tb_cs_steal_front.sv
`timescale 1ns/1ps
module tb_cs_steal_front;

  localparam int AW = 16;
  localparam int DW = 16;
  localparam int HOLD = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [3:0]    req_i = '0, addr_drv_i = '0;
  logic          file_gate_i = 1'b0, ent_strobe_i = 1'b0;
  logic [DW-1:0] iobus_i = '0;
  logic [AW-1:0] ext_addr_i = '0;
  logic          ld_valid_i = 1'b0, ld_last_i = 1'b0;
  logic [AW-1:0] ld_addr_i = '0;
  logic [DW-1:0] ld_data_i = '0;
  logic          ld_ready_o, ld_done_o, lreq_o, busy_o, entry_sample_o, mem_we_o, bus_err_o;
  logic [AW-1:0] laddr_o, mem_addr_o;
  logic [DW-1:0] ldata_o, sbr_o;
  logic [3:0]    grant_o;
  logic [2:0]    phase_o;

  cs_steal_front #(.AW(AW), .DW(DW), .HOLD_CYC(HOLD)) dut (.*);

  always #5 clk = ~clk;

  int errors = 0, checks = 0;
  bit finished = 0;

  task automatic chk(input string tag, input string sig, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, sig, act, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  int m_sync, m_busy, m_ph, m_g, m_wr, m_ls, m_cnt, m_done, m_err, m_last;
  int pend[4];
  logic [DW-1:0] m_sbr, m_ldata;
  logic [AW-1:0] m_laddr;

  function automatic bit m_es();
    if (!(m_busy != 0 && m_ph == 3)) return 1'b0;
    case (m_g)
      0: return file_gate_i;
      1: return ent_strobe_i || (m_ls == 1);
      2: return 1'b0;
      default: return 1'b1;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sync = 0; m_busy = 0; m_ph = 0; m_g = -1; m_wr = 0; m_ls = 0; m_cnt = 0;
      m_done = 0; m_err = 0; m_last = 0; m_sbr = '0; m_laddr = '0; m_ldata = '0;
    end else if (m_sync < 2) begin
      m_sync++;
    end else begin
      int o_busy, o_ph, o_g, o_ls, found;
      bit es;
      logic [3:0] reqv, drv, gv;
      o_busy = m_busy; o_ph = m_ph; o_g = m_g; o_ls = m_ls;
      es = m_es();
      reqv = req_i | ((o_ls == 1) ? 4'b0010 : 4'b0000);
      gv = (o_busy != 0) ? (4'b1 << o_g) : 4'b0;
      drv = addr_drv_i | ((o_ls == 1 && o_g == 1 && o_busy != 0) ? 4'b0010 : 4'b0000);
      m_err = (o_busy != 0 && (drv & ~gv) != 0) ? 1 : 0;
      if (es) begin
        m_wr = 1;
        m_sbr = (o_g == 1 && o_ls == 1) ? m_ldata : iobus_i;
      end
      if (o_busy == 0) begin
        found = -1;
        for (int i = 3; i >= 0; i--) if (reqv[i]) found = i;
        if (found >= 0) begin m_busy = 1; m_ph = 0; m_g = found; m_wr = 0; end
      end else if (o_ph == 7) begin
        m_busy = 0; m_ph = 0; m_g = -1;
        if (pend[o_g] > 0) pend[o_g]--;
      end else m_ph++;
      case (o_ls)
        0: if (ld_valid_i) begin
             m_ls = 1; m_laddr = ld_addr_i; m_ldata = ld_data_i; m_last = ld_last_i; m_done = 0;
           end
        1: if (o_busy != 0 && o_ph == 7 && o_g == 1) begin
             m_ls = 2; m_cnt = HOLD - 1; if (m_last != 0) m_done = 1;
           end
        default: if (m_cnt == 0) m_ls = 0; else m_cnt--;
      endcase
    end
  end

  // drive requests and moving bus values
  int tick = 0;
  always @(negedge clk) begin
    tick++;
    for (int i = 0; i < 4; i++) req_i[i] = (pend[i] > 0);
    iobus_i = DW'(tick * 16'h1357);
    ext_addr_i = AW'(16'h4000 + tick);
  end

  // compare every clock
  always @(negedge clk) begin
    #1;
    if (!finished) begin
      logic [3:0] eg;
      logic [AW-1:0] ea;
      eg = (m_busy != 0) ? (4'b1 << m_g) : 4'b0;
      ea = (m_busy == 0) ? '0 : ((m_g == 1 && m_ls == 1) ? m_laddr : ext_addr_i);
      chk("R2", "grant_o", grant_o, eg);
      chk("R3", "busy_o", busy_o, m_busy[0]);
      chk("R3", "phase_o", phase_o, m_ph);
      chk("R4/R5/R6/R7", "entry_sample_o", entry_sample_o, m_es());
      chk("R9", "sbr_o", sbr_o, m_sbr);
      chk("R9", "mem_we_o", mem_we_o, (m_busy != 0 && m_ph == 6 && m_wr != 0));
      chk("R9", "mem_addr_o", mem_addr_o, ea);
      chk("R10", "lreq_o", lreq_o, (m_ls == 1));
      chk("R10", "ld_ready_o", ld_ready_o, (m_ls == 0));
      chk("R10", "laddr_o", laddr_o, m_laddr);
      chk("R10", "ldata_o", ldata_o, m_ldata);
      chk("R11", "ld_done_o", ld_done_o, m_done[0]);
      chk("R12", "bus_err_o", bus_err_o, m_err[0]);
    end
  end

  // record order of new grants at the ports
  int order[$];
  logic busy_prev = 1'b0;
  always @(negedge clk) begin
    if (busy_o && !busy_prev)
      for (int i = 0; i < 4; i++) if (grant_o[i]) order.push_back(i);
    busy_prev = busy_o;
  end

  int err_seen = 0, es_seen = 0;
  always @(negedge clk) begin
    if (bus_err_o) err_seen++;
    if (entry_sample_o) es_seen++;
  end

  task automatic settle();
    int quiet = 0;
    while (quiet < 3) begin
      @(negedge clk);
      if (m_busy == 0 && m_ls == 0 && pend[0] + pend[1] + pend[2] + pend[3] == 0) quiet++;
      else quiet = 0;
    end
  endtask

  task automatic ask(input int lvl);
    @(negedge clk);
    pend[lvl]++;
  endtask

  task automatic load_word(input logic [AW-1:0] a, input logic [DW-1:0] d, input bit last);
    @(negedge clk);
    while (m_ls != 0) @(negedge clk);
    ld_valid_i = 1'b1; ld_addr_i = a; ld_data_i = d; ld_last_i = last;
    @(negedge clk);
    ld_valid_i = 1'b0; ld_last_i = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      finished = 1;
      errors++; checks++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) pend[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    #1;
    chk("R1", "grant_o", grant_o, 0);
    chk("R1", "busy_o", busy_o, 0);
    chk("R1", "phase_o", phase_o, 0);
    chk("R1", "sbr_o", sbr_o, 0);
    chk("R1", "ld_ready_o", ld_ready_o, 1);
    chk("R1", "ld_done_o", ld_done_o, 0);
    chk("R1", "bus_err_o", bus_err_o, 0);

    // R7 level 3, twice back to back
    es_seen = 0;
    ask(3); ask(3);
    settle();
    chk("R7", "level3 samples", es_seen, 2);

    // R4 level 0 without, then with, the gate
    es_seen = 0; file_gate_i = 1'b0;
    ask(0); settle();
    chk("R4", "level0 no gate samples", es_seen, 0);
    file_gate_i = 1'b1;
    ask(0); settle();
    file_gate_i = 1'b0;
    chk("R4", "level0 gated samples", es_seen, 1);

    // R6 level 2 never
    es_seen = 0;
    ask(2); settle();
    chk("R6", "level2 samples", es_seen, 0);

    // R5 level 1 strobe off then on
    es_seen = 0;
    ask(1); settle();
    chk("R5", "level1 no strobe samples", es_seen, 0);
    ent_strobe_i = 1'b1;
    ask(1); settle();
    ent_strobe_i = 1'b0;
    chk("R5", "level1 strobe samples", es_seen, 1);

    // R2 all four at once: serviced 0,1,2,3
    order.delete();
    @(negedge clk);
    pend[3]++; pend[2]++; pend[1]++; pend[0]++;
    settle();
    chk("R2", "grants seen", order.size(), 4);
    for (int i = 0; i < 4 && i < order.size(); i++) chk("R2", "grant order", order[i], i);

    // R10 R11 loader stream interleaved with level 0
    file_gate_i = 1'b1;
    ask(0);
    load_word(16'h0120, 16'h3000, 1'b0);
    ask(0);
    load_word(16'h0121, 16'hA5A5, 1'b0);
    load_word(16'h0122, 16'h5A5A, 1'b1);
    settle();
    file_gate_i = 1'b0;
    chk("R11", "ld_done_o after stream", ld_done_o, 1);
    chk("R9", "sbr_o holds last loader word", sbr_o, 16'h5A5A);
    load_word(16'h0200, 16'h1111, 1'b0);
    #1;
    chk("R11", "ld_done_o cleared on accept", ld_done_o, 0);
    settle();

    // R12 contention: level 2 drives during a level 0 cycle
    err_seen = 0;
    ask(0);
    @(negedge clk);
    while (m_busy == 0) @(negedge clk);
    addr_drv_i = 4'b0100;
    repeat (2) @(negedge clk);
    addr_drv_i = 4'b0000;
    settle();
    chk("R12", "bus_err seen", (err_seen > 0), 1);

    repeat (3) @(negedge clk);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule